// File: doc/BRIEF.md
# Half-Bridge Supply Lockout and Transient Hold Gate

This block sits between the deadtime stage and the output drivers of a multi-phase half-bridge gate driver. Each phase has a high-side command and a low-side command. The block decides whether each command may reach its driver, based on three kinds of digitized health flags. The first is a shared flag for the low-side/logic supply. The second is a per-phase flag for the floating high-side supply. The third is a per-phase flag that reports a negative excursion of the switch node. The analog comparators and the transient detector are outside the block. Their flags arrive asynchronously, and each one passes through a two-flop synchronizer before it is used.

When the shared supply is low, every output is blocked. When a phase's floating supply is low, only that phase's high output is blocked. Once the floating supply is healthy again, a per-phase arm latch keeps the high output off until a fresh rising edge of the high command arrives. A negative transient that persists for a qualification time starts a fixed hold window, and the phase's high output stays off for that window. A new qualifying transient during the window starts the window again. Both times are clock-cycle parameters.

Top module: `gd_supply_gate`

## Requirements
- R1: While the synchronized shared supply flag is 0, every phase's high and low outputs are 0 one clock later.
- R2: When the shared supply flag returns to 1, the outputs follow their commands again with no new command edge needed, provided the high side of that phase is still armed.
- R3: While a phase's synchronized floating supply flag is 0, that phase's high output is 0. Its low output still follows its low command, and the other phases are unaffected.
- R4: An arm latch is cleared while the floating supply flag is 0. It is set by a 0-to-1 change of the high command (seen between consecutive clock edges) while that flag is 1. A high command that is held at 1 through recovery leaves the high output at 0.
- R5: During reset all outputs are 0 and every arm latch is clear. A high command that is already 1 when reset is released does not count as a rising edge.
- R6: A synchronized transient flag that stays 1 for QUAL_CYC consecutive cycles blocks the phase's high output for HOLD_CYC cycles. A run of QUAL_CYC-1 cycles has no effect.
- R7: A new qualifying transient that arrives during a hold window reloads the window to its full HOLD_CYC length.
- R8: Supply and transient flags take two clock edges to synchronize. The outputs are registered and follow hin/lin one clock edge after those commands are sampled.
- R9: If a supply flag never becomes 1 after reset, the outputs that supply controls stay 0 whatever the commands do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_ok_raw | input | 1 | Shared low-side/logic supply healthy (asynchronous) |
| vbs_ok_raw | input | NPH | Per-phase floating supply healthy (asynchronous) |
| negtr_raw | input | NPH | Per-phase negative switch-node transient present (asynchronous) |
| hin | input | NPH | High-side commands from the deadtime stage |
| lin | input | NPH | Low-side commands from the deadtime stage |
| ho | output | NPH | Gated high-side driver outputs |
| lo | output | NPH | Gated low-side driver outputs |

## Verification
The bench targets the re-arm rule in several ways. It holds the high command at 1 across floating-supply recovery and across reset release, where a design that re-enables on level would turn the high output on. It also drops the shared supply while the phase is armed, where a design that clears the arm latch on that event would keep the high output stuck off after recovery. For transients, it sends a run exactly one cycle short of the qualification time, which a design with an off-by-one qualifier would wrongly act on. It then fires a second qualifying run partway through a hold window; a design that does not reload the window would release the high output early. A random phase mixes all flags with command traffic against a cycle model, so that an error in synchronizer depth or output latency shows up as a one-cycle mismatch.

// File: rtl/gdg_pkg.sv
package gdg_pkg;
  // Saturating increment toward a ceiling.
  function automatic int unsigned run_step(input int unsigned cur, input int unsigned ceil);
    return (cur >= ceil) ? ceil : cur + 1;
  endfunction

  // Count down to zero and stay there.
  function automatic int unsigned hold_step(input int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction
endpackage

// File: rtl/gdg_sync.sv
module gdg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/gdg_phase_gate.sv
module gdg_phase_gate
  import gdg_pkg::*;
#(
  parameter int QUAL_CYC = 5,
  parameter int HOLD_CYC = 450
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_s,
  input  logic vbs_s,
  input  logic neg_s,
  input  logic hin,
  input  logic lin,
  output logic ho,
  output logic lo
);
  localparam int RW = $clog2(QUAL_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic          hin_prev;
  logic          armed;
  logic [RW-1:0] run_len;
  logic [HW-1:0] hold_left;

  // Named internal events for the assertions.
  logic hin_rise, arm_eff, qual_evt, hold_act;

  assign hin_rise = hin & ~hin_prev;
  assign arm_eff  = vbs_s & (armed | hin_rise);
  assign qual_evt = neg_s && (run_len == RW'(QUAL_CYC - 1));
  assign hold_act = (hold_left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hin_prev  <= 1'b1;   // a level present at reset release is not an edge
      armed     <= 1'b0;
      run_len   <= '0;
      hold_left <= '0;
      ho        <= 1'b0;
      lo        <= 1'b0;
    end else begin
      hin_prev  <= hin;
      armed     <= arm_eff;
      run_len   <= neg_s ? RW'(run_step(32'(run_len), QUAL_CYC)) : '0;
      hold_left <= qual_evt ? HW'(HOLD_CYC) : HW'(hold_step(32'(hold_left)));
      lo        <= vcc_s & lin;
      ho        <= vcc_s & arm_eff & ~hold_act & hin;
    end
  end

  p_vbs_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vbs_s |=> !ho);
  p_hold_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |=> !ho);
  p_hold_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    qual_evt |=> (hold_left == HW'(HOLD_CYC)));
  p_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !hin_rise) |=> !ho);
  p_lo_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_s |=> (lo == $past(lin)));
endmodule

// File: rtl/gd_supply_gate.sv
module gd_supply_gate #(
  parameter int NPH      = 3,
  parameter int SYNC_N   = 2,
  parameter int QUAL_CYC = 5,
  parameter int HOLD_CYC = 450
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vcc_ok_raw,
  input  logic [NPH-1:0] vbs_ok_raw,
  input  logic [NPH-1:0] negtr_raw,
  input  logic [NPH-1:0] hin,
  input  logic [NPH-1:0] lin,
  output logic [NPH-1:0] ho,
  output logic [NPH-1:0] lo
);
  logic           vcc_s;
  logic [NPH-1:0] vbs_s;
  logic [NPH-1:0] neg_s;

  gdg_sync #(.W(1), .STAGES(SYNC_N)) u_sync_vcc (
    .clk(clk), .rst_n(rst_n), .d(vcc_ok_raw), .q(vcc_s));
  gdg_sync #(.W(NPH), .STAGES(SYNC_N)) u_sync_vbs (
    .clk(clk), .rst_n(rst_n), .d(vbs_ok_raw), .q(vbs_s));
  gdg_sync #(.W(NPH), .STAGES(SYNC_N)) u_sync_neg (
    .clk(clk), .rst_n(rst_n), .d(negtr_raw), .q(neg_s));

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    gdg_phase_gate #(.QUAL_CYC(QUAL_CYC), .HOLD_CYC(HOLD_CYC)) u_ph (
      .clk(clk), .rst_n(rst_n), .vcc_s(vcc_s), .vbs_s(vbs_s[p]),
      .neg_s(neg_s[p]), .hin(hin[p]), .lin(lin[p]), .ho(ho[p]), .lo(lo[p]));
  end

  p_vcc_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_s |=> (ho == '0 && lo == '0));
  p_reset_low_r5: assert property (@(posedge clk)
    !rst_n |-> (ho == '0 && lo == '0));
endmodule

// File: tb/tb_gd_supply_gate.sv
module tb_gd_supply_gate;
  localparam int NPH = 3;
  localparam int Q   = 5;
  localparam int H   = 450;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok_raw = 1'b0;
  logic [NPH-1:0] vbs_ok_raw = '0, negtr_raw = '0, hin = '0, lin = '0;
  logic [NPH-1:0] ho, lo;

  gd_supply_gate #(.NPH(NPH), .SYNC_N(2), .QUAL_CYC(Q), .HOLD_CYC(H)) dut (
    .clk(clk), .rst_n(rst_n), .vcc_ok_raw(vcc_ok_raw), .vbs_ok_raw(vbs_ok_raw),
    .negtr_raw(negtr_raw), .hin(hin), .lin(lin), .ho(ho), .lo(lo));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  string cur_req = "R5";
  bit done = 0;

  // Cycle model built from the requirements.
  logic m_vcc1, m_vcc2;
  logic [NPH-1:0] m_vbs1, m_vbs2, m_neg1, m_neg2, m_arm, m_hprev, m_ho, m_lo;
  int m_run [NPH];
  int m_hold [NPH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vcc1 <= 0; m_vcc2 <= 0; m_vbs1 <= '0; m_vbs2 <= '0;
      m_neg1 <= '0; m_neg2 <= '0; m_arm <= '0; m_hprev <= '1;
      m_ho <= '0; m_lo <= '0;
      for (int p = 0; p < NPH; p++) begin m_run[p] <= 0; m_hold[p] <= 0; end
    end else begin
      for (int p = 0; p < NPH; p++) begin
        logic edge_seen, may_drive, qual;
        edge_seen = hin[p] && !m_hprev[p];
        may_drive = m_vbs2[p] && (m_arm[p] || edge_seen);
        qual = m_neg2[p] && (m_run[p] + 1 == Q);
        m_lo[p]   <= m_vcc2 && lin[p];
        m_ho[p]   <= m_vcc2 && may_drive && (m_hold[p] == 0) && hin[p];
        m_arm[p]  <= may_drive;
        m_run[p]  <= m_neg2[p] ? ((m_run[p] < Q) ? m_run[p] + 1 : Q) : 0;
        m_hold[p] <= qual ? H : ((m_hold[p] > 0) ? m_hold[p] - 1 : 0);
      end
      m_hprev <= hin;
      m_vcc1 <= vcc_ok_raw; m_vcc2 <= m_vcc1;
      m_vbs1 <= vbs_ok_raw; m_vbs2 <= m_vbs1;
      m_neg1 <= negtr_raw;  m_neg2 <= m_neg1;
    end
  end

  task automatic check(input string req, input logic [NPH-1:0] act, input logic [NPH-1:0] exp_v, input string what);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp_v, $time);
    end
  endtask

  // Model comparison every cycle, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      check(cur_req, ho, m_ho, "ho vs model");
      check(cur_req, lo, m_lo, "lo vs model");
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    // R5: reset state and a high command already high at release
    hin = '1; lin = '0; vcc_ok_raw = 1; vbs_ok_raw = '1;
    step(3);
    check("R5", ho, '0, "ho in reset");
    check("R5", lo, '0, "lo in reset");
    rst_n = 1;
    step(12);
    check("R5", ho, '0, "ho after release with hin held high");

    // R4: a falling then rising command arms the high side
    cur_req = "R4";
    hin = '0; step(2); hin = '1; step(2);
    check("R4", ho, '1, "ho after fresh rising edge");

    // R9: supplies never come up
    cur_req = "R9";
    rst_n = 0; vcc_ok_raw = 0; vbs_ok_raw = '0; step(2); rst_n = 1;
    for (int i = 0; i < 40; i++) begin
      hin = NPH'($urandom); lin = NPH'($urandom); step(1);
    end
    check("R9", ho | lo, '0, "outputs with no supply");

    // R8: synchronizer and output latency
    cur_req = "R8";
    hin = '0; lin = '1; vbs_ok_raw = '1;
    vcc_ok_raw = 1; step(2);
    check("R8", lo, '0, "lo two edges after supply rise");
    step(1);
    check("R8", lo, '1, "lo three edges after supply rise");
    hin = '1; lin = '0; step(1);
    check("R8", ho, '1, "ho one edge after hin rise");

    // R3: floating supply loss on phase 1 only
    cur_req = "R3";
    vbs_ok_raw[1] = 0;
    for (int i = 0; i < 30; i++) begin lin = NPH'($urandom); step(1); end
    check("R3", ho, 3'b101, "ho with phase1 floating supply low");
    cur_req = "R4";
    vbs_ok_raw[1] = 1; step(10);
    check("R4", ho, 3'b101, "held hin after floating recovery");
    hin[1] = 0; step(1); hin[1] = 1; step(2);
    check("R4", ho, 3'b111, "ho after new edge");

    // R1/R2: shared supply loss and recovery with commands held
    cur_req = "R1";
    lin = '1; vcc_ok_raw = 0; step(4);
    check("R1", ho | lo, '0, "outputs with shared supply low");
    cur_req = "R2";
    vcc_ok_raw = 1; step(4);
    check("R2", ho, '1, "ho resumes without new edge");
    check("R2", lo, '1, "lo resumes");
    lin = '0;

    // R6: short run ignored, qualifying run holds
    cur_req = "R6";
    negtr_raw[0] = 1; step(Q - 1); negtr_raw[0] = 0; step(6);
    check("R6", ho, '1, "short transient ignored");
    negtr_raw[0] = 1; step(Q); negtr_raw[0] = 0; step(5);
    check("R6", ho, 3'b110, "ho held after qualifying transient");
    step(H);
    check("R6", ho, '1, "ho back after hold window");

    // R7: retrigger in window
    cur_req = "R7";
    negtr_raw[2] = 1; step(Q); negtr_raw[2] = 0; step(200);
    negtr_raw[2] = 1; step(Q); negtr_raw[2] = 0;
    step(H - 100);
    check("R7", ho[2], 1'b0, "ho still held after retrigger");
    step(120);
    check("R7", ho[2], 1'b1, "ho back after reloaded window");

    // Mixed random traffic (R2 and all rules against model)
    cur_req = "R2 random";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(99) < 3) vcc_ok_raw = ~vcc_ok_raw;
      if (!vcc_ok_raw && $urandom_range(9) == 0) vcc_ok_raw = 1;
      for (int p = 0; p < NPH; p++) begin
        if ($urandom_range(99) < 2) vbs_ok_raw[p] = ~vbs_ok_raw[p];
        if (!vbs_ok_raw[p] && $urandom_range(19) == 0) vbs_ok_raw[p] = 1;
        if ($urandom_range(199) == 0) negtr_raw[p] = 1;
        else if ($urandom_range(3) == 0) negtr_raw[p] = 0;
        if ($urandom_range(7) == 0) hin[p] = ~hin[p];
        if ($urandom_range(7) == 0) lin[p] = ~lin[p];
      end
      step(1);
    end
    finish_run();
  end
endmodule